// File: doc/BRIEF.md
# Parity-Check Message Unit with Split-Format Lookups

This block computes the replies of one parity check in an iterative soft decoder. Each transaction offers one signed message from every variable node attached to the check. Every variable node then gets back a reply that leaves out its own input. The check degree is a parameter and defaults to 32. Messages are two's-complement words, six bits by default, with two fraction bits (a quarter-step grid spanning -8 to 7.75).

Two magnitude rules are available, and the mode input picks one per transaction. The exact rule uses the curve phi(x) = -ln(tanh(x/2)). A forward table maps each input magnitude to a finer grid with five fraction bits. The table outputs are summed once. Each lane subtracts its own term from the sum, and an inverse table maps the remainder back to the quarter-step grid. This keeps the word length at six bits while placing most of the levels where the curve is steep. The cheaper rule ignores the tables. It takes the smallest magnitude among the other lanes, lowers it by a programmable offset and stops at zero. In both modes the sign of each reply is the product of the other lanes' signs.

The unit is a two-stage pipeline. A word is accepted whenever the input strobe is high, and the result appears with its own strobe two cycles later.

Top module: `check_node_unit`

## Requirements
- R1: A word presented with inVld high at a rising edge yields outVld high during exactly the cycle after the following edge, so the latency is two edges. Consecutive valid words give consecutive results, and outVld is low otherwise.
- R2: While rstN is low and until the first result, outVld is 0 and every lane of msgOut is 0.
- R3: Lane j of msgOut is two's complement with its sign in the top bit. The value is negative exactly when the XOR of the top bits of all other input lanes is 1 and the magnitude is nonzero. A zero magnitude is always output as 0.
- R4: The input code 100000 (-8.0) is treated as magnitude 31 (7.75). No output lane ever carries the code 100000.
- R5: In exact mode (modeMinSum = 0), an input magnitude m (units of 1/4) maps to term t = round(32·phi(m/4)), clamped to 31. Magnitude 0 maps to 31.
- R6: In exact mode, the terms of all lanes are summed once with a saturating accumulator. Lane j uses e = sum - t_j, clamped to 31.
- R7: In exact mode, the output magnitude is round(4·phi(e/32)), clamped to 31. An e of 0 gives 31.
- R8: In offset mode (modeMinSum = 1), the output magnitude of lane j is max(min over i≠j of |x_i| - offsetBeta, 0), with offsetBeta in units of 1/4.
- R9: In offset mode, the lane holding a unique smallest magnitude receives the second smallest. When two lanes share the smallest magnitude, every lane receives that value.
- R10: msgOut keeps its value in every cycle that does not deliver a new result.
- R11: modeMinSum and offsetBeta are sampled together with the word. Changing them while that word is in flight does not alter its result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inVld | input | 1 | Input word valid |
| modeMinSum | input | 1 | 0 selects the exact table rule, 1 selects the offset-minimum rule |
| offsetBeta | input | W-1 (5) | Offset subtracted in offset mode, units of 1/4 |
| msgIn | input | DEGREE·W (192) | Incoming messages, lane j at bits [j·W +: W] |
| outVld | output | 1 | Result valid |
| msgOut | output | DEGREE·W (192) | Outgoing messages, lane j at bits [j·W +: W] |

## Verification
The hardest situations to reach from the ports come from the exclusion logic. One is a lane that holds the unique minimum and must see the second minimum. Another is a tie at the minimum. A third is an exact-mode sum where one lane's own term dominates. The bench reaches these with generated patterns that place a single small or zero magnitude, a pair of equal minima, or the code -8.0 at a chosen lane among large magnitudes. It also changes the mode and offset in the cycle right after a word is accepted, and alternates modes on back-to-back words, so that the sampled control is shown to travel with its data.

// File: rtl/cnu_pkg.sv
package cnu_pkg;

  // Load strobes from control to datapath
  typedef struct packed {
    logic ldStage1;
    logic ldStage2;
  } cnu_strobe_t;

  // Quantized phi(x) = -ln(tanh(x/2)); input code has inFrac fraction bits,
  // result has outFrac fraction bits, rounded to nearest and clamped to maxCode.
  function automatic int phiCode(int code, int inFrac, int outFrac, int maxCode);
    real x;
    real e;
    real p;
    real r;
    if (code <= 0) return maxCode;
    x = real'(code) / real'(1 << inFrac);
    e = $exp(-x);
    p = $ln((1.0 + e) / (1.0 - e));
    r = p * real'(1 << outFrac) + 0.5;
    if (r >= real'(maxCode)) return maxCode;
    return $rtoi(r);
  endfunction

endpackage

// File: rtl/cnu_phi_rom.sv
module cnu_phi_rom
  import cnu_pkg::*;
#(
  parameter int MAG_W    = 5,
  parameter int IN_FRAC  = 2,
  parameter int OUT_FRAC = 5
) (
  input  logic [MAG_W-1:0] addr,
  output logic [MAG_W-1:0] data
);
  localparam int DEPTH = 1 << MAG_W;
  localparam int MAXC  = DEPTH - 1;

  logic [MAG_W-1:0] tab [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    localparam int VAL = phiCode(g, IN_FRAC, OUT_FRAC, MAXC);
    assign tab[g] = MAG_W'(VAL);
  end

  assign data = tab[addr];
endmodule

// File: rtl/cnu_ctrl.sv
module cnu_ctrl
  import cnu_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inVld,
  output cnu_strobe_t strobe,
  output logic        outVld
);
  logic stage1Vld;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stage1Vld <= 1'b0;
      outVld    <= 1'b0;
    end else begin
      stage1Vld <= inVld;
      outVld    <= stage1Vld;
    end
  end

  assign strobe.ldStage1 = inVld;
  assign strobe.ldStage2 = stage1Vld;

  // R1: accepted word yields a result two edges later
  p_latency_r1: assert property (@(posedge clk) disable iff (!rstN)
    inVld |-> ##2 outVld);
  // R1: no spurious result
  p_no_spurious_r1: assert property (@(posedge clk) disable iff (!rstN)
    !inVld |-> ##2 !outVld);
endmodule

// File: rtl/cnu_datapath.sv
module cnu_datapath
  import cnu_pkg::*;
#(
  parameter int DEGREE = 32,
  parameter int W      = 6,
  parameter int FRAC_A = 2,
  parameter int ACC_W  = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  cnu_strobe_t         strobe,
  input  logic                modeMinSum,
  input  logic [W-2:0]        offsetBeta,
  input  logic [DEGREE*W-1:0] msgIn,
  output logic [DEGREE*W-1:0] msgOut
);
  localparam int MAG_W   = W - 1;
  localparam int MAG_MAX = (1 << MAG_W) - 1;
  localparam int FRAC_B  = MAG_W;
  localparam int IDX_W   = (DEGREE > 1) ? $clog2(DEGREE) : 1;
  localparam logic [W-1:0] MOST_NEG = {1'b1, {MAG_W{1'b0}}};

  // ---------------- stage 1: magnitudes, forward terms, aggregates
  logic [MAG_W-1:0] laneMag  [DEGREE];
  logic [MAG_W-1:0] laneTerm [DEGREE];
  logic [DEGREE-1:0] laneSgn;

  for (genvar g = 0; g < DEGREE; g++) begin : g_in
    logic [W-1:0] rawV;
    logic [W-1:0] negV;
    assign rawV = msgIn[g*W +: W];
    assign negV = ~rawV + W'(1);
    assign laneSgn[g] = rawV[W-1];
    assign laneMag[g] = (rawV == MOST_NEG) ? MAG_W'(MAG_MAX)
                      : (rawV[W-1] ? negV[MAG_W-1:0] : rawV[MAG_W-1:0]);

    cnu_phi_rom #(.MAG_W(MAG_W), .IN_FRAC(FRAC_A), .OUT_FRAC(FRAC_B)) u_fwd (
      .addr(laneMag[g]),
      .data(laneTerm[g])
    );
  end

  logic             aggPar;
  logic [ACC_W-1:0] aggSum;
  logic [MAG_W-1:0] aggMin1;
  logic [MAG_W-1:0] aggMin2;
  logic [IDX_W-1:0] aggIdx;

  always_comb begin
    logic [ACC_W:0] accWide;
    aggPar  = 1'b0;
    aggSum  = '0;
    aggMin1 = MAG_W'(MAG_MAX);
    aggMin2 = MAG_W'(MAG_MAX);
    aggIdx  = '0;
    for (int i = 0; i < DEGREE; i++) begin
      aggPar  = aggPar ^ laneSgn[i];
      accWide = {1'b0, aggSum} + (ACC_W+1)'(laneTerm[i]);
      aggSum  = accWide[ACC_W] ? {ACC_W{1'b1}} : accWide[ACC_W-1:0];
      if (laneMag[i] < aggMin1) begin
        aggMin2 = aggMin1;
        aggMin1 = laneMag[i];
        aggIdx  = IDX_W'(i);
      end else if (laneMag[i] < aggMin2) begin
        aggMin2 = laneMag[i];
      end
    end
  end

  logic [DEGREE-1:0] s1Sgn;
  logic [MAG_W-1:0]  s1Term [DEGREE];
  logic              s1Par;
  logic [ACC_W-1:0]  s1Sum;
  logic [MAG_W-1:0]  s1Min1;
  logic [MAG_W-1:0]  s1Min2;
  logic [IDX_W-1:0]  s1Idx;
  logic              s1Mode;
  logic [MAG_W-1:0]  s1Beta;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Sgn  <= '0;
      s1Par  <= 1'b0;
      s1Sum  <= '0;
      s1Min1 <= '0;
      s1Min2 <= '0;
      s1Idx  <= '0;
      s1Mode <= 1'b0;
      s1Beta <= '0;
      for (int i = 0; i < DEGREE; i++) s1Term[i] <= '0;
    end else if (strobe.ldStage1) begin
      s1Sgn  <= laneSgn;
      s1Par  <= aggPar;
      s1Sum  <= aggSum;
      s1Min1 <= aggMin1;
      s1Min2 <= aggMin2;
      s1Idx  <= aggIdx;
      s1Mode <= modeMinSum;
      s1Beta <= offsetBeta;
      for (int i = 0; i < DEGREE; i++) s1Term[i] <= laneTerm[i];
    end
  end

  // ---------------- stage 2: marginalize, inverse map or offset minimum, sign
  logic [W-1:0] laneOut [DEGREE];

  for (genvar g = 0; g < DEGREE; g++) begin : g_out
    logic [ACC_W-1:0] ext;
    logic [MAG_W-1:0] invAddr;
    logic [MAG_W-1:0] spMag;
    logic [MAG_W-1:0] msPick;
    logic [MAG_W-1:0] msMag;
    logic [MAG_W-1:0] mag;
    logic [W-1:0]     posV;
    logic             negOut;

    assign ext = (s1Sum >= ACC_W'(s1Term[g])) ? (s1Sum - ACC_W'(s1Term[g])) : '0;
    assign invAddr = (ext > ACC_W'(MAG_MAX)) ? MAG_W'(MAG_MAX) : ext[MAG_W-1:0];

    cnu_phi_rom #(.MAG_W(MAG_W), .IN_FRAC(FRAC_B), .OUT_FRAC(FRAC_A)) u_inv (
      .addr(invAddr),
      .data(spMag)
    );

    assign msPick = (IDX_W'(g) == s1Idx) ? s1Min2 : s1Min1;
    assign msMag  = (msPick > s1Beta) ? (msPick - s1Beta) : '0;
    assign mag    = s1Mode ? msMag : spMag;
    assign negOut = s1Par ^ s1Sgn[g];
    assign posV   = {1'b0, mag};
    assign laneOut[g] = (negOut && (mag != '0)) ? (~posV + W'(1)) : posV;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      msgOut <= '0;
    end else if (strobe.ldStage2) begin
      for (int i = 0; i < DEGREE; i++) msgOut[i*W +: W] <= laneOut[i];
    end
  end

  // ---------------- assertions
  // R10: output register holds when no result is delivered
  p_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.ldStage2 |=> $stable(msgOut));

  // R9: the captured minima are ordered
  p_min_order_r9: assert property (@(posedge clk) disable iff (!rstN)
    s1Min1 <= s1Min2);

  for (genvar g = 0; g < DEGREE; g++) begin : g_chk
    logic [W-1:0] oLane;
    logic [W-1:0] oAbs;
    assign oLane = msgOut[g*W +: W];
    assign oAbs  = oLane[W-1] ? (~oLane + W'(1)) : oLane;

    // R4: the most negative code never leaves the unit
    p_no_most_neg_r4: assert property (@(posedge clk) disable iff (!rstN)
      oLane != MOST_NEG);

    // R8: offset-mode magnitude never exceeds the second minimum
    p_ms_bound_r8: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.ldStage2 && s1Mode) |=> (oAbs <= W'($past(s1Min2))));
  end
endmodule

// File: rtl/check_node_unit.sv
module check_node_unit
  import cnu_pkg::*;
#(
  parameter int DEGREE = 32,
  parameter int W      = 6,
  parameter int FRAC_A = 2,
  parameter int ACC_W  = $clog2(DEGREE * ((1 << (W - 1)) - 1) + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inVld,
  input  logic                modeMinSum,
  input  logic [W-2:0]        offsetBeta,
  input  logic [DEGREE*W-1:0] msgIn,
  output logic                outVld,
  output logic [DEGREE*W-1:0] msgOut
);
  cnu_strobe_t strobe;

  cnu_ctrl u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .inVld (inVld),
    .strobe(strobe),
    .outVld(outVld)
  );

  cnu_datapath #(
    .DEGREE(DEGREE),
    .W     (W),
    .FRAC_A(FRAC_A),
    .ACC_W (ACC_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .modeMinSum(modeMinSum),
    .offsetBeta(offsetBeta),
    .msgIn     (msgIn),
    .msgOut    (msgOut)
  );
endmodule

// File: tb/tb_check_node_unit.sv
`timescale 1ns/1ps
module tb_check_node_unit;
  localparam int DEG = 32;
  localparam int W   = 6;
  localparam int FW  = DEG * W;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          inVld = 1'b0;
  logic          modeMinSum = 1'b0;
  logic [W-2:0]  offsetBeta = '0;
  logic [FW-1:0] msgIn = '0;
  logic          outVld;
  logic [FW-1:0] msgOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  check_node_unit #(.DEGREE(DEG), .W(W)) dut (
    .clk(clk), .rstN(rstN), .inVld(inVld), .modeMinSum(modeMinSum),
    .offsetBeta(offsetBeta), .msgIn(msgIn), .outVld(outVld), .msgOut(msgOut)
  );

  typedef struct packed {
    logic [2:0] kind;
    logic [7:0] seed;
    logic       mode;
    logic [4:0] beta;
  } vec_t;

  // kind 0 mixed, 1 large with one small lane, 2 zeros with one lane,
  // 3 most-negative code at a lane, 4 two equal minima
  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 8'd3,  1'b0, 5'd0},   // R5 R6 R7
    '{3'd0, 8'd11, 1'b1, 5'd0},   // R8
    '{3'd0, 8'd29, 1'b1, 5'd2},   // R8 with offset
    '{3'd1, 8'd7,  1'b0, 5'd0},   // R6 own term dominates
    '{3'd1, 8'd7,  1'b1, 5'd1},   // R9 unique minimum
    '{3'd2, 8'd4,  1'b0, 5'd0},   // R5 zero magnitudes
    '{3'd2, 8'd9,  1'b1, 5'd0},   // R8 zeros
    '{3'd3, 8'd0,  1'b0, 5'd0},   // R4 exact
    '{3'd3, 8'd17, 1'b1, 5'd0},   // R4 offset
    '{3'd4, 8'd2,  1'b1, 5'd0},   // R9 tie
    '{3'd4, 8'd21, 1'b1, 5'd6},   // R8 offset exceeds minimum
    '{3'd0, 8'd55, 1'b0, 5'd0}    // R3 signs
  };

  function automatic int bPhi(int code, int inFrac, int outFrac);
    real x, e, r;
    if (code <= 0) return 31;
    x = real'(code) / real'(1 << inFrac);
    e = $exp(-x);
    r = $ln((1.0 + e) / (1.0 - e)) * real'(1 << outFrac) + 0.5;
    if (r >= 31.0) return 31;
    return $rtoi(r);
  endfunction

  function automatic logic [FW-1:0] genVec(int kind, int seed);
    logic [FW-1:0] v;
    int x;
    for (int i = 0; i < DEG; i++) begin
      case (kind)
        0: x = (seed * 37 + i * i * 13 + i * 7 + 5) % 64;
        1: x = (i == seed % DEG) ? 1 : ((i % 3 == 0) ? 64 - (20 + i % 8) : 20 + i % 8);
        2: x = (i == seed % DEG) ? 61 : 0;
        3: x = (i == seed % DEG) ? 32 : (seed + i * 11) % 64;
        default: x = ((i == seed % DEG) || (i == (seed + 5) % DEG)) ? ((i % 2 == 1) ? 60 : 4)
                     : ((i % 2 == 0) ? 25 : 64 - 25);
      endcase
      v[i*W +: W] = W'(x);
    end
    return v;
  endfunction

  function automatic logic [FW-1:0] model(logic [FW-1:0] inV, bit mode, int beta);
    logic [FW-1:0] r;
    int mag [DEG];
    int trm [DEG];
    bit sg [DEG];
    int tot = 0;
    bit par = 1'b0;
    for (int i = 0; i < DEG; i++) begin
      int v;
      v = int'(inV[i*W +: W]);
      sg[i] = v >= 32;
      mag[i] = (v == 32) ? 31 : (sg[i] ? 64 - v : v);
      trm[i] = bPhi(mag[i], 2, 5);
      tot += trm[i];
      par ^= sg[i];
    end
    for (int j = 0; j < DEG; j++) begin
      int m, o;
      bit s;
      if (mode) begin
        int mn = 1000;
        for (int i = 0; i < DEG; i++) if (i != j && mag[i] < mn) mn = mag[i];
        m = (mn > beta) ? mn - beta : 0;
      end else begin
        int e = tot - trm[j];
        if (e > 31) e = 31;
        m = bPhi(e, 5, 2);
      end
      s = par ^ sg[j];
      o = (s && m != 0) ? 64 - m : m;
      r[j*W +: W] = W'(o);
    end
    return r;
  endfunction

  task automatic cmpOut(string req, logic [FW-1:0] exp);
    checks++;
    if (msgOut !== exp || outVld !== 1'b1) begin
      failures++;
      for (int j = 0; j < DEG; j++)
        if (msgOut[j*W +: W] !== exp[j*W +: W]) begin
          $display("FAIL %s lane %0d actual=%0d expected=%0d", req, j,
                   msgOut[j*W +: W], exp[j*W +: W]);
          break;
        end
      if (outVld !== 1'b1)
        $display("FAIL %s outVld actual=%0b expected=1", req, outVld);
    end
  endtask

  task automatic chkBit(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  // drive one word at a falling edge; returns after the next falling edge
  task automatic sendOne(logic [FW-1:0] v, bit mode, int beta);
    msgIn = v; modeMinSum = mode; offsetBeta = 5'(beta); inVld = 1'b1;
    @(negedge clk);
    inVld = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [FW-1:0] v, e0, e1;
    repeat (3) @(negedge clk);
    // R2: reset state
    chkBit("R2 outVld", outVld, 1'b0);
    checks++;
    if (msgOut !== '0) begin
      failures++;
      $display("FAIL R2 msgOut actual=%h expected=0", msgOut);
    end
    rstN = 1'b1;
    @(negedge clk);

    // table walk
    for (int k = 0; k < NV; k++) begin
      v  = genVec(int'(VECS[k].kind), int'(VECS[k].seed));
      e0 = model(v, VECS[k].mode, int'(VECS[k].beta));
      @(negedge clk);
      sendOne(v, VECS[k].mode, int'(VECS[k].beta));
      chkBit("R1 early", outVld, 1'b0);
      @(negedge clk);
      cmpOut(VECS[k].mode ? "R8 R9 R3" : "R5 R6 R7 R3", e0);
      @(negedge clk);
      chkBit("R1 single", outVld, 1'b0);
    end

    // R3: one negative lane, offset mode, beta 0
    v = '0;
    for (int i = 0; i < DEG; i++) v[i*W +: W] = (i == 3) ? W'(64 - 10) : W'(10);
    @(negedge clk);
    sendOne(v, 1'b1, 0);
    @(negedge clk);
    checks++;
    if (msgOut[3*W +: W] !== 6'd10 || msgOut[0 +: W] !== 6'(64 - 10)) begin
      failures++;
      $display("FAIL R3 lane3/lane0 actual=%0d/%0d expected=10/54",
               msgOut[3*W +: W], msgOut[0 +: W]);
    end

    // R4: most negative code among 31s
    v = '0;
    for (int i = 0; i < DEG; i++) v[i*W +: W] = (i == 0) ? 6'd32 : 6'd31;
    @(negedge clk);
    sendOne(v, 1'b1, 0);
    @(negedge clk);
    checks++;
    if (msgOut[0 +: W] !== 6'd31 || msgOut[W +: W] !== 6'd33) begin
      failures++;
      $display("FAIL R4 lane0/lane1 actual=%0d/%0d expected=31/33",
               msgOut[0 +: W], msgOut[W +: W]);
    end

    // R10: hold while inputs change without a valid
    e0 = msgOut;
    for (int c = 0; c < 3; c++) begin
      msgIn = genVec(0, 40 + c); modeMinSum = ~modeMinSum;
      @(negedge clk);
    end
    checks++;
    if (msgOut !== e0 || outVld !== 1'b0) begin
      failures++;
      $display("FAIL R10 actual=%h expected=%h", msgOut, e0);
    end

    // R11: change mode and offset right after acceptance
    v  = genVec(1, 12);
    e0 = model(v, 1'b0, 0);
    @(negedge clk);
    sendOne(v, 1'b0, 0);
    modeMinSum = 1'b1; offsetBeta = 5'd31;
    @(negedge clk);
    cmpOut("R11", e0);

    // R1 back-to-back, alternating modes
    v  = genVec(0, 77);
    e0 = model(v, 1'b1, 1);
    e1 = model(genVec(4, 9), 1'b0, 0);
    @(negedge clk);
    msgIn = v; modeMinSum = 1'b1; offsetBeta = 5'd1; inVld = 1'b1;
    @(negedge clk);
    msgIn = genVec(4, 9); modeMinSum = 1'b0; offsetBeta = 5'd0;
    @(negedge clk);
    inVld = 1'b0;
    cmpOut("R1 R11 first", e0);
    @(negedge clk);
    cmpOut("R1 R11 second", e1);
    @(negedge clk);
    chkBit("R1 tail", outVld, 1'b0);

    // R2: reset in the middle clears results
    rstN = 1'b0;
    @(negedge clk);
    checks++;
    if (msgOut !== '0 || outVld !== 1'b0) begin
      failures++;
      $display("FAIL R2 mid-reset actual=%h expected=0", msgOut);
    end
    rstN = 1'b1;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule